// File: doc/BRIEF.md
# Fragment Program Instruction Stream Parser

This block takes a fragment-program stream of 32-bit words, one word per accepted beat on a valid/ready input, and rebuilds whole instructions from it. An instruction has a fixed head of four words: a control word that carries the opcode, the destination and the end flag, followed by three source-descriptor words. When any of the three source descriptors names the constant register type, the stream also carries four inline constant words (x, y, z, w) straight after that head. The parser collects these words too, so a program's instructions are four or eight words long.

Each complete instruction is handed to the consumer as one record. The record holds the four head words, the decoded opcode, a flag that says whether constants were attached, and the four constant lanes. The record stays on the output until the consumer takes it, and the input is stalled in the meantime. An end flag in an instruction's control word ends the program. The parser then swallows the single trailer word that closes the stream and enters a done state. It stays there, discarding any further input, until a start pulse rearms it.

Top module: `frag_stream_parser`

## Requirements
- R1: After a synchronous reset, `rec_valid` and `done` are 0 and `in_ready` is 1, and the next accepted word is taken as control word 0 of a new instruction.
- R2: The four head words of an instruction appear in `rec_insn` with word k at bits [32k+31:32k] (control word in the lowest lane), and `rec_opcode` equals bits [29:24] of the control word.
- R3: If bits [1:0] of any of head words 1, 2 or 3 equal 2 (constant type), the next four accepted words are captured as constant lanes x, y, z, w at `rec_const` bits [31:0], [63:32], [95:64] and [127:96], and `rec_has_const` is 1.
- R4: If no source word has type 2 (types 0, 1 and 3 do not count), the record is offered right after the fourth head word, `rec_has_const` is 0, `rec_const` is all zero, and the next accepted word starts the next instruction.
- R5: While `rec_valid` is 1 and `rec_ready` is 0, the record stays valid and unchanged and `in_ready` is 0, so no input word is consumed.
- R6: When bit 0 of the control word is 1, after that record is accepted exactly one further word is consumed as a trailer without forming an instruction, and `done` then rises.
- R7: While `done` is 1, input words are accepted (`in_ready` is 1) and discarded, and no record is produced.
- R8: A one-cycle `start` pulse while `done` is 1 clears `done` and resumes parsing at control word 0. A `start` pulse at any other time has no effect on parsing.
- R9: A synchronous reset in the middle of an instruction discards the partially collected words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Rearm pulse, acted on only while done |
| in_valid | input | 1 | Stream word is offered |
| in_ready | output | 1 | Parser accepts a word this cycle |
| in_word | input | 32 | Stream word |
| rec_valid | output | 1 | Instruction record is on the output |
| rec_ready | input | 1 | Consumer takes the record |
| rec_insn | output | 128 | Four head words, control word in the lowest lane |
| rec_opcode | output | 6 | Opcode field of the control word |
| rec_has_const | output | 1 | Inline constants were attached |
| rec_const | output | 128 | Constant lanes x, y, z, w from low to high |
| done | output | 1 | Program end reached and trailer consumed |

## Verification
The assertions assume that `start` is a single-cycle pulse and that the consumer may hold `rec_ready` low for any time. They also assume the producer sends a well-formed stream: four constant words follow every instruction whose sources name the constant type, and one trailer follows the final instruction. The stimulus keeps within these limits. It walks a table of well-formed programs and holds `in_valid` with a stable word until the word is accepted. Words that are out of place, such as a word offered while a record is pending or words after the end, are sent only in directed cases that test their rejection or discard.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   typedef enum logic [2:0] {
      ST_HEAD  = 3'd0,
      ST_CONST = 3'd1,
      ST_EMIT  = 3'd2,
      ST_TRAIL = 3'd3,
      ST_IDLE  = 3'd4
   } fsp_state_e;

   localparam int unsigned FSP_WORD_W   = 32;
   localparam int unsigned FSP_SRC_CNT  = 3;
   localparam int unsigned FSP_CONST_N  = 4;
   localparam int unsigned FSP_TYPE_W   = 2;
   localparam int unsigned FSP_TYPE_CST = 2;
   localparam int unsigned FSP_OPC_LSB  = 24;
   localparam int unsigned FSP_OPC_W    = 6;
   localparam int unsigned FSP_END_BIT  = 0;

endpackage

// File: rtl/fsp_src_type_chk.sv
module fsp_src_type_chk #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned TYPE_W   = 2,
   parameter int unsigned TYPE_CST = 2
) (
   input  logic [WORD_W-1:0] word,
   output logic              is_const
);
   localparam logic [TYPE_W-1:0] CST_CODE = TYPE_W'(TYPE_CST);

   always_comb is_const = (word[TYPE_W-1:0] == CST_CODE);
endmodule

// File: rtl/fsp_word_bank.sv
module fsp_word_bank #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned IDX_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    we,
   input  logic [IDX_W-1:0]        idx,
   input  logic [WORD_W-1:0]       din,
   output logic [DEPTH*WORD_W-1:0] dout
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_lane
      logic [WORD_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (rst || clr) begin
            lane_q <= '0;
         end else if (we && (idx == IDX_W'(g))) begin
            lane_q <= din;
         end
      end
      assign dout[g*WORD_W +: WORD_W] = lane_q;
   end
endmodule

// File: rtl/fsp_seq.sv
module fsp_seq
   import fsp_pkg::*;
#(
   parameter int unsigned HEAD_N  = 4,
   parameter int unsigned CONST_N = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             in_valid,
   input  logic             word_is_const,
   input  logic             word_end,
   input  logic             rec_ready,
   output logic             in_ready,
   output logic             rec_valid,
   output logic             has_const,
   output logic             done,
   output logic             head_we,
   output logic             const_we,
   output logic             head_first,
   output logic [IDX_W-1:0] wr_idx
);
   localparam logic [IDX_W-1:0] HEAD_LAST  = IDX_W'(HEAD_N - 1);
   localparam logic [IDX_W-1:0] CONST_LAST = IDX_W'(CONST_N - 1);

   fsp_state_e       state_q;
   logic [IDX_W-1:0] cnt_q;
   logic             cst_q;
   logic             last_q;
   logic             fire;

   always_comb begin
      in_ready   = (state_q != ST_EMIT);
      fire       = in_valid && in_ready;
      head_we    = fire && (state_q == ST_HEAD);
      const_we   = fire && (state_q == ST_CONST);
      head_first = head_we && (cnt_q == '0);
      wr_idx     = cnt_q;
      rec_valid  = (state_q == ST_EMIT);
      done       = (state_q == ST_IDLE);
      has_const  = cst_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_HEAD;
         cnt_q   <= '0;
         cst_q   <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_HEAD: if (fire) begin
               if (cnt_q == '0) begin
                  last_q <= word_end;
                  cst_q  <= 1'b0;
               end else if (word_is_const) begin
                  cst_q  <= 1'b1;
               end
               if (cnt_q == HEAD_LAST) begin
                  cnt_q   <= '0;
                  state_q <= (cst_q || word_is_const) ? ST_CONST : ST_EMIT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_CONST: if (fire) begin
               if (cnt_q == CONST_LAST) begin
                  cnt_q   <= '0;
                  state_q <= ST_EMIT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_EMIT: if (rec_ready) begin
               state_q <= last_q ? ST_TRAIL : ST_HEAD;
            end
            ST_TRAIL: if (fire) begin
               state_q <= ST_IDLE;
            end
            ST_IDLE: if (start) begin
               state_q <= ST_HEAD;
               cnt_q   <= '0;
            end
            default: state_q <= ST_HEAD;
         endcase
      end
   end
endmodule

// File: rtl/frag_stream_parser.sv
module frag_stream_parser
   import fsp_pkg::*;
#(
   parameter int unsigned WORD_W       = FSP_WORD_W,
   parameter int unsigned SRC_CNT      = FSP_SRC_CNT,
   parameter int unsigned CONST_N      = FSP_CONST_N,
   parameter int unsigned TYPE_W       = FSP_TYPE_W,
   parameter int unsigned TYPE_CST     = FSP_TYPE_CST,
   parameter int unsigned OPC_LSB      = FSP_OPC_LSB,
   parameter int unsigned OPC_W        = FSP_OPC_W,
   parameter int unsigned END_BIT      = FSP_END_BIT,
   parameter bit          ZERO_NO_CST  = 1'b1,
   localparam int unsigned HEAD_N      = SRC_CNT + 1,
   localparam int unsigned MAX_N       = (HEAD_N > CONST_N) ? HEAD_N : CONST_N,
   localparam int unsigned IDX_W       = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      start,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [WORD_W-1:0]         in_word,
   output logic                      rec_valid,
   input  logic                      rec_ready,
   output logic [HEAD_N*WORD_W-1:0]  rec_insn,
   output logic [OPC_W-1:0]          rec_opcode,
   output logic                      rec_has_const,
   output logic [CONST_N*WORD_W-1:0] rec_const,
   output logic                      done
);
   if (SRC_CNT < 1) begin : g_bad_src
      $error("frag_stream_parser: SRC_CNT must be at least 1");
   end
   if (CONST_N < 1) begin : g_bad_cst
      $error("frag_stream_parser: CONST_N must be at least 1");
   end
   if (TYPE_W < 1 || TYPE_W > WORD_W) begin : g_bad_type
      $error("frag_stream_parser: TYPE_W out of range");
   end
   if (TYPE_CST >= (1 << TYPE_W)) begin : g_bad_code
      $error("frag_stream_parser: TYPE_CST does not fit TYPE_W");
   end
   if (OPC_LSB + OPC_W > WORD_W || END_BIT >= WORD_W) begin : g_bad_fld
      $error("frag_stream_parser: control word field outside the word");
   end

   logic             word_is_const;
   logic             head_we;
   logic             const_we;
   logic             head_first;
   logic             const_clr;
   logic [IDX_W-1:0] wr_idx;

   fsp_src_type_chk #(
      .WORD_W   (WORD_W),
      .TYPE_W   (TYPE_W),
      .TYPE_CST (TYPE_CST)
   ) u_type (
      .word     (in_word),
      .is_const (word_is_const)
   );

   fsp_seq #(
      .HEAD_N  (HEAD_N),
      .CONST_N (CONST_N),
      .IDX_W   (IDX_W)
   ) u_seq (
      .clk           (clk),
      .rst           (rst),
      .start         (start),
      .in_valid      (in_valid),
      .word_is_const (word_is_const),
      .word_end      (in_word[END_BIT]),
      .rec_ready     (rec_ready),
      .in_ready      (in_ready),
      .rec_valid     (rec_valid),
      .has_const     (rec_has_const),
      .done          (done),
      .head_we       (head_we),
      .const_we      (const_we),
      .head_first    (head_first),
      .wr_idx        (wr_idx)
   );

   if (ZERO_NO_CST) begin : g_clr_each
      assign const_clr = head_first;
   end else begin : g_clr_keep
      assign const_clr = 1'b0;
   end

   fsp_word_bank #(
      .WORD_W (WORD_W),
      .DEPTH  (HEAD_N),
      .IDX_W  (IDX_W)
   ) u_head (
      .clk  (clk),
      .rst  (rst),
      .clr  (1'b0),
      .we   (head_we),
      .idx  (wr_idx),
      .din  (in_word),
      .dout (rec_insn)
   );

   fsp_word_bank #(
      .WORD_W (WORD_W),
      .DEPTH  (CONST_N),
      .IDX_W  (IDX_W)
   ) u_cst (
      .clk  (clk),
      .rst  (rst),
      .clr  (const_clr),
      .we   (const_we),
      .idx  (wr_idx),
      .din  (in_word),
      .dout (rec_const)
   );

   assign rec_opcode = rec_insn[OPC_LSB +: OPC_W];
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned SRC_CNT  = 3,
   parameter int unsigned CONST_N  = 4,
   parameter int unsigned TYPE_W   = 2,
   parameter int unsigned TYPE_CST = 2
) (
   input logic                            clk,
   input logic                            rst,
   input logic                            start,
   input logic                            in_ready,
   input logic                            rec_valid,
   input logic                            rec_ready,
   input logic [(SRC_CNT+1)*WORD_W-1:0]   rec_insn,
   input logic                            rec_has_const,
   input logic [CONST_N*WORD_W-1:0]       rec_const,
   input logic                            done
);
   logic any_src_cst;
   always_comb begin
      any_src_cst = 1'b0;
      for (int s = 1; s <= SRC_CNT; s++) begin
         if (rec_insn[s*WORD_W +: TYPE_W] == TYPE_W'(TYPE_CST)) any_src_cst = 1'b1;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rec_valid && !done && in_ready));

   assert_flag_matches_R3: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> (rec_has_const == any_src_cst));

   assert_zero_lanes_R4: assert property (@(posedge clk) disable iff (rst)
      (rec_valid && !rec_has_const) |-> (rec_const == '0));

   assert_stall_input_R5: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> !in_ready);

   assert_hold_record_R5: assert property (@(posedge clk) disable iff (rst)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_insn) && $stable(rec_const)
                                     && $stable(rec_has_const)));

   assert_no_rec_done_R7: assert property (@(posedge clk) disable iff (rst)
      done |-> (!rec_valid && in_ready));

   assert_done_sticks_R7: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

   assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
      (done && start) |=> (!done && !rec_valid));
endmodule

bind frag_stream_parser fsp_checker #(
   .WORD_W   (WORD_W),
   .SRC_CNT  (SRC_CNT),
   .CONST_N  (CONST_N),
   .TYPE_W   (TYPE_W),
   .TYPE_CST (TYPE_CST)
) u_fsp_checker (
   .clk           (clk),
   .rst           (rst),
   .start         (start),
   .in_ready      (in_ready),
   .rec_valid     (rec_valid),
   .rec_ready     (rec_ready),
   .rec_insn      (rec_insn),
   .rec_has_const (rec_has_const),
   .rec_const     (rec_const),
   .done          (done)
);

// File: tb/tb_frag_stream_parser.sv
module tb_frag_stream_parser;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [31:0]  in_word = '0;
   logic         rec_valid;
   logic         rec_ready = 1'b0;
   logic [127:0] rec_insn;
   logic [5:0]   rec_opcode;
   logic         rec_has_const;
   logic [127:0] rec_const;
   logic         done;

   always #5 clk = ~clk;

   frag_stream_parser dut (
      .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_insn(rec_insn),
      .rec_opcode(rec_opcode), .rec_has_const(rec_has_const), .rec_const(rec_const),
      .done(done)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // head words 0..3, then constant words x..w (used only when a source is type 2)
   localparam logic [31:0] VEC [6][8] = '{
      '{32'h0100_1E00, 32'h0000_0001, 32'h0000_0004, 32'h0000_0001, 0, 0, 0, 0},
      '{32'h0200_1E02, 32'h0000_0002, 32'h0000_0000, 32'h0000_0001,
        32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 32'h4080_0000},
      '{32'h0400_0A04, 32'h0000_0000, 32'h0000_0001, 32'h0000_E402,
        32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444},
      '{32'h0300_1E00, 32'h0000_0003, 32'h0000_0007, 32'h0000_000B, 0, 0, 0, 0},
      '{32'h0500_0200, 32'h0000_0001, 32'h0000_1B06, 32'h0000_0000,
        32'hDEAD_BEEF, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF},
      '{32'h0600_1E01, 32'h0000_0004, 32'h0000_0008, 32'h0000_0001, 0, 0, 0, 0}
   };

   function automatic bit any_cst(input logic [31:0] a, input logic [31:0] b,
                                  input logic [31:0] c);
      return (a[1:0] == 2'd2) || (b[1:0] == 2'd2) || (c[1:0] == 2'd2);
   endfunction

   task automatic send_word(input logic [31:0] w);
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_rec();
      for (int k = 0; k < 40 && !rec_valid; k++) @(negedge clk);
   endtask

   task automatic pop();
      rec_ready = 1'b1;
      @(negedge clk);
      rec_ready = 1'b0;
   endtask

   task automatic check_rec(input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3,
                            input logic [127:0] cexp, input bit hexp, input string tag);
      chk(rec_valid == 1'b1, {tag, " R2 record valid"}, 128'(rec_valid), 128'd1);
      chk(rec_insn == {w3, w2, w1, w0}, {tag, " R2 head words"}, rec_insn, {w3, w2, w1, w0});
      chk(rec_opcode == w0[29:24], {tag, " R2 opcode"}, 128'(rec_opcode), 128'(w0[29:24]));
      chk(rec_has_const == hexp, {tag, hexp ? " R3 flag" : " R4 flag"},
          128'(rec_has_const), 128'(hexp));
      chk(rec_const == cexp, {tag, hexp ? " R3 lanes" : " R4 lanes zero"}, rec_const, cexp);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(!rec_valid && !done && in_ready, "R1 reset state",
          128'({rec_valid, done, in_ready}), 128'b001);

      // table walk: one program, last entry carries the end flag
      for (int i = 0; i < 6; i++) begin
         bit h;
         logic [127:0] cx;
         h  = any_cst(VEC[i][1], VEC[i][2], VEC[i][3]);
         cx = h ? {VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]} : 128'd0;
         for (int j = 0; j < 4; j++) send_word(VEC[i][j]);
         if (h) for (int j = 4; j < 8; j++) send_word(VEC[i][j]);
         wait_rec();
         check_rec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], cx, h, $sformatf("vec%0d", i));
         pop();
         chk(!rec_valid, "R4 record released", 128'(rec_valid), 128'd0);
      end

      // R6: trailer consumed, then done
      chk(!done && in_ready, "R6 waiting for trailer", 128'({done, in_ready}), 128'b01);
      send_word(32'h0000_0001);
      chk(done && !rec_valid, "R6 done after trailer", 128'({done, rec_valid}), 128'b10);

      // R7: words after the end are discarded
      for (int k = 0; k < 5; k++) send_word(32'h0700_0000 | 32'(k) << 1 | 32'h2);
      repeat (2) @(negedge clk);
      chk(done && !rec_valid, "R7 discard after end", 128'({done, rec_valid}), 128'b10);

      // R8: rearm
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done && in_ready && !rec_valid, "R8 rearm",
          128'({done, in_ready, rec_valid}), 128'b010);

      // R5: backpressure with a word waiting on the input
      send_word(32'h0800_1E00); send_word(32'h1); send_word(32'h0); send_word(32'h5);
      wait_rec();
      in_valid = 1'b1;
      in_word  = 32'h0900_0600;
      for (int k = 0; k < 3; k++) begin
         chk(rec_valid && !in_ready, "R5 stall held", 128'({rec_valid, in_ready}), 128'b10);
         chk(rec_insn == {32'h5, 32'h0, 32'h1, 32'h0800_1E00}, "R5 record stable",
             rec_insn, {32'h5, 32'h0, 32'h1, 32'h0800_1E00});
         @(negedge clk);
      end
      pop();
      @(negedge clk);
      in_valid = 1'b0;
      send_word(32'h1); send_word(32'h1); send_word(32'h0);
      wait_rec();
      check_rec(32'h0900_0600, 32'h1, 32'h1, 32'h0, 128'd0, 1'b0, "R5 held word");
      pop();

      // R8: start outside done has no effect
      send_word(32'h0A00_1E00);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      send_word(32'h0); send_word(32'h2); send_word(32'h1);
      for (int j = 0; j < 4; j++) send_word(32'hC0DE_0000 | 32'(j));
      wait_rec();
      check_rec(32'h0A00_1E00, 32'h0, 32'h2, 32'h1,
                {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000}, 1'b1,
                "R8 start ignored");
      pop();

      // R9: reset mid-instruction
      send_word(32'h0B00_0001); send_word(32'h2);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!rec_valid && !done && in_ready, "R9 R1 state after mid reset",
          128'({rec_valid, done, in_ready}), 128'b001);
      send_word(32'h0C00_1E00); send_word(32'h4); send_word(32'h1); send_word(32'h0);
      wait_rec();
      check_rec(32'h0C00_1E00, 32'h4, 32'h1, 32'h0, 128'd0, 1'b0, "R9 clean restart");
      pop();

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule